// File: doc/BRIEF.md
# GPIO Interrupt Aggregator

This block collects per-pin interrupt events from several 32-pin GPIO banks and turns them into one interrupt line per bank. Each bank has a group of 32 sticky status bits, one per pin. Each group also has a per-bit mask, with separate set and clear write ports, and a masked result view. A status bit captures its event whether or not its mask bit is open, so software can poll pins that never raise an interrupt. The group line reaches the processor's interrupt controller only when a separate per-group gate bit is set.

Software uses a word-addressed register port with one write per cycle and combinational read data. Group `g` occupies word addresses `4*g` to `4*g+3`. Offset 0 is the sticky status, written 1-to-clear. Offset 1 is the mask-set port and offset 2 is the mask-clear port. Offset 3 is the read-only result. The per-group gate register sits at word address `4*NUM_GROUPS`, with bit `g` gating group `g`. The interrupt line is level-sensitive. It stays high while any unmasked status bit of an open group is pending, so an interrupt controller that drops its pending flag sees the request come back.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: Event input bit `evt_i[32*g+n]` sets only status bit n of group g; the status, mask and result registers all use bit n for pin n.
- R2: A write to status offset 0 clears each status bit whose write-data bit is 1 and leaves every bit with a 0 in the write data unchanged.
- R3: An event latches into its status bit when the mask bit is 0, and the status bit stays set until it is cleared.
- R4: Writing 1s to offset 1 sets those mask bits, and writing 1s to offset 2 clears them; 0 data bits in either write leave the mask unchanged.
- R5: Reading offset 3 returns status AND mask; a write to offset 3 changes nothing.
- R6: `irq_o[g]` is high one clock after a cycle in which gate bit g is 1 and group g has at least one result bit set, and low one clock after any other cycle.
- R7: While another result bit of the group is still pending, clearing one result bit leaves `irq_o[g]` high; it drops only once no result bit remains.
- R8: Writing all ones to a group's status offset clears every latched event in that group.
- R9: When an event and a 1-to-clear write hit the same status bit in the same cycle, the bit ends up set.
- R10: Reads of offset 1 and offset 2 both return the current mask.
- R11: After reset, all status, mask and gate bits and all interrupt outputs are 0, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_GROUPS*GRP_W | Per-pin event requests, group g in bits [32g+31:32g] |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | GRP_W | Write data |
| bus_rdata | output | GRP_W | Read data for bus_addr (combinational) |
| irq_o | output | NUM_GROUPS | Registered interrupt line, one per group |

## Verification
A wrong status bit shows on the status and result reads in the cycle after the event or write. It reaches `irq_o` one clock later, so a lost or wrongly held event appears at the ports within two clocks. A mask or gate fault shows up only when the matching status bit is pending. The bench therefore sets status, mask and gate together in every case, and checks bits on both sides of the active ones. Collisions between an event and a clear, and partial clears inside a group with several pending bits, cover the cases where a wrong ordering would hide behind a correct final level.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register offsets for the GPIO interrupt aggregator.
// Assumes word addressing with four registers per group.
package gpio_irq_pkg;

    localparam int REGS_PER_GRP = 4;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MSET   = 2'd1,
        SEL_MCLR   = 2'd2,
        SEL_RESULT = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_irq_group.sv
// One interrupt group: sticky status bits, a mask with set/clear ports,
// and the masked result. Assumes the write strobes are mutually exclusive
// and already qualified by address decode.
module gpio_irq_group #(
    parameter int GRP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] evt,
    input  logic             stat_clr_we,
    input  logic             mask_set_we,
    input  logic             mask_clr_we,
    input  logic [GRP_W-1:0] wdata,
    output logic [GRP_W-1:0] stat_q,
    output logic [GRP_W-1:0] mask_q,
    output logic [GRP_W-1:0] result,
    output logic             any_pending
);

    logic [GRP_W-1:0] clr_bits;
    logic [GRP_W-1:0] stat_d;
    logic [GRP_W-1:0] mask_d;

    // Bits a 1-to-clear write removes this cycle
    always_comb clr_bits = stat_clr_we ? wdata : '0;

    // Next status: keep what is not cleared, events win over clears
    always_comb stat_d = (stat_q & ~clr_bits) | evt;

    // Next mask: set port and clear port only touch bits written as 1
    always_comb begin
        mask_d = mask_q;
        if (mask_set_we) mask_d = mask_d | wdata;
        if (mask_clr_we) mask_d = mask_d & ~wdata;
    end

    // Status and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= stat_d;
            mask_q <= mask_d;
        end
    end

    // Masked result and its reduction
    always_comb result      = stat_q & mask_q;
    always_comb any_pending = |result;

    // R2: bits not written as 1 stay set
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stat_q & ~clr_bits)) == $past(stat_q & ~clr_bits)));

    // R3 / R9: every event bit is set next cycle, whatever the mask or clear
    p_evt_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

    // R4: set port raises the written bits
    p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set_we |=> ((mask_q & $past(wdata)) == $past(wdata)));

    // R4: clear port lowers the written bits
    p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clr_we |=> ((mask_q & $past(wdata)) == '0));

    // R4: mask holds without a mask write
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_set_we && !mask_clr_we) |=> $stable(mask_q));

endmodule

// File: rtl/gpio_irq_decode.sv
// Address decode and read multiplexer for the aggregator register port.
// Assumes word addresses: group g at 4g..4g+3, gate register at 4*NUM_GROUPS.
module gpio_irq_decode
    import gpio_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 32,
    parameter int ADDR_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [NUM_GROUPS*GRP_W-1:0] stat_all,
    input  logic [NUM_GROUPS*GRP_W-1:0] mask_all,
    input  logic [NUM_GROUPS*GRP_W-1:0] res_all,
    input  logic [NUM_GROUPS-1:0]       gate_q,
    output logic [NUM_GROUPS-1:0]       stat_clr_we,
    output logic [NUM_GROUPS-1:0]       mask_set_we,
    output logic [NUM_GROUPS-1:0]       mask_clr_we,
    output logic                        gate_we,
    output logic [GRP_W-1:0]            bus_rdata
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(NUM_GROUPS * REGS_PER_GRP);

    logic [IDX_W-1:0] grp_idx;
    reg_sel_e         sel;

    // Split the address into group index and register select
    always_comb begin
        grp_idx = bus_addr[ADDR_W-1:2];
        sel     = reg_sel_e'(bus_addr[1:0]);
    end

    // Gate register write strobe
    always_comb gate_we = bus_wr && (bus_addr == GATE_ADDR);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_strobe
        localparam logic [IDX_W-1:0] GIDX = IDX_W'(g);
        // Per-group write strobes
        always_comb begin
            stat_clr_we[g] = bus_wr && (grp_idx == GIDX) && (sel == SEL_STATUS);
            mask_set_we[g] = bus_wr && (grp_idx == GIDX) && (sel == SEL_MSET);
            mask_clr_we[g] = bus_wr && (grp_idx == GIDX) && (sel == SEL_MCLR);
        end
    end

    // Read multiplexer; unmapped addresses read zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == GATE_ADDR) begin
            bus_rdata = GRP_W'(gate_q);
        end else begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (grp_idx == IDX_W'(g)) begin
                    unique case (sel)
                        SEL_STATUS: bus_rdata = stat_all[g*GRP_W +: GRP_W];
                        SEL_MSET:   bus_rdata = mask_all[g*GRP_W +: GRP_W];
                        SEL_MCLR:   bus_rdata = mask_all[g*GRP_W +: GRP_W];
                        SEL_RESULT: bus_rdata = res_all[g*GRP_W +: GRP_W];
                        default:    bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    // R4: at most one register written per cycle
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> $onehot0({stat_clr_we, mask_set_we, mask_clr_we, gate_we}));

endmodule

// File: rtl/gpio_irq_aggregator.sv
// GPIO interrupt aggregator top: one group per GPIO bank, a per-group
// gate register, and one registered interrupt line per group.
// Assumes events are one-cycle requests or levels synchronous to clk.
module gpio_irq_aggregator
    import gpio_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 32,
    parameter int ADDR_W     = $clog2(NUM_GROUPS * REGS_PER_GRP + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*GRP_W-1:0] evt_i,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [GRP_W-1:0]            bus_wdata,
    output logic [GRP_W-1:0]            bus_rdata,
    output logic [NUM_GROUPS-1:0]       irq_o
);

    logic [NUM_GROUPS*GRP_W-1:0] stat_all;
    logic [NUM_GROUPS*GRP_W-1:0] mask_all;
    logic [NUM_GROUPS*GRP_W-1:0] res_all;
    logic [NUM_GROUPS-1:0]       grp_any;
    logic [NUM_GROUPS-1:0]       stat_clr_we;
    logic [NUM_GROUPS-1:0]       mask_set_we;
    logic [NUM_GROUPS-1:0]       mask_clr_we;
    logic                        gate_we;
    logic [NUM_GROUPS-1:0]       gate_q;

    gpio_irq_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .GRP_W      (GRP_W),
        .ADDR_W     (ADDR_W)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .stat_all    (stat_all),
        .mask_all    (mask_all),
        .res_all     (res_all),
        .gate_q      (gate_q),
        .stat_clr_we (stat_clr_we),
        .mask_set_we (mask_set_we),
        .mask_clr_we (mask_clr_we),
        .gate_we     (gate_we),
        .bus_rdata   (bus_rdata)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        gpio_irq_group #(
            .GRP_W (GRP_W)
        ) u_group (
            .clk         (clk),
            .rst_n       (rst_n),
            .evt         (evt_i[g*GRP_W +: GRP_W]),
            .stat_clr_we (stat_clr_we[g]),
            .mask_set_we (mask_set_we[g]),
            .mask_clr_we (mask_clr_we[g]),
            .wdata       (bus_wdata),
            .stat_q      (stat_all[g*GRP_W +: GRP_W]),
            .mask_q      (mask_all[g*GRP_W +: GRP_W]),
            .result      (res_all[g*GRP_W +: GRP_W]),
            .any_pending (grp_any[g])
        );

        // R6: gate closed means the line is low next cycle
        p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !gate_q[g] |=> !irq_o[g]);

        // R7: a pending result behind an open gate keeps the line high
        p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_q[g] && grp_any[g]) |=> irq_o[g]);
    end

    // Gate register, written as a whole word
    always_ff @(posedge clk) begin
        if (!rst_n)       gate_q <= '0;
        else if (gate_we) gate_q <= bus_wdata[NUM_GROUPS-1:0];
    end

    // Registered interrupt lines: gated OR of each group's result
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= '0;
        else        irq_o <= grp_any & gate_q;
    end

    // R11: outputs stay low in the cycle after reset
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));

endmodule

// File: tb/gpio_irq_aggregator_test.sv
module gpio_irq_aggregator_test;

    localparam int NG   = 4;
    localparam int W    = 32;
    localparam int AW   = 5;
    localparam int GATE = NG * 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NG*W-1:0] evt_i = '0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [W-1:0]    bus_wdata = '0;
    logic [W-1:0]    bus_rdata;
    logic [NG-1:0]   irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    gpio_irq_aggregator uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #2.5 clk = ~clk;

    // Vector table: group, events, mask, gate, expected result, expected line
    localparam int NV = 6;
    localparam int          V_GRP [NV] = '{0, 1, 2, 3, 1, 0};
    localparam logic [31:0] V_EVT [NV] = '{32'h0000_00FF, 32'h8000_0001, 32'hFFFF_0000,
                                           32'h0000_1000, 32'h8000_0000, 32'hAAAA_5555};
    localparam logic [31:0] V_MSK [NV] = '{32'h0000_000F, 32'h0000_0002, 32'hF0F0_F0F0,
                                           32'h0000_1000, 32'h8000_0000, 32'hFFFF_FFFF};
    localparam bit          V_GATE[NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [31:0] V_RES [NV] = '{32'h0000_000F, 32'h0000_0000, 32'hF0F0_0000,
                                           32'h0000_1000, 32'h8000_0000, 32'hAAAA_5555};
    localparam bit          V_IRQ [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input int g, input logic [31:0] v);
        @(negedge clk);
        evt_i = '0; evt_i[g*W +: W] = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int g = 0; g < NG; g++) begin
            wr(g*4 + 0, 32'hFFFF_FFFF);
            wr(g*4 + 2, 32'hFFFF_FFFF);
        end
        wr(GATE, 32'h0);
        idle(2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11 irq after reset", 32'(irq_o), 32'h0);
        for (int a = 0; a < GATE + 1; a++) begin
            rd(a, d);
            chk("R11 register zero after reset", d, 32'h0);
        end
        rd(GATE + 3, d);
        chk("R11 unmapped read", d, 32'h0);

        // R5 R6 R3: table walk
        for (int i = 0; i < NV; i++) begin
            clear_all();
            wr(V_GRP[i]*4 + 1, V_MSK[i]);
            wr(GATE, 32'(V_GATE[i]) << V_GRP[i]);
            pulse(V_GRP[i], V_EVT[i]);
            idle(1);
            rd(V_GRP[i]*4 + 3, d);
            chk("R5 result vector", d, V_RES[i]);
            rd(V_GRP[i]*4 + 0, d);
            chk("R3 status vector", d, V_EVT[i]);
            chk("R6 irq vector", 32'(irq_o), 32'(V_IRQ[i]) << V_GRP[i]);
        end

        // R1: pin 5 of group 1 lands only in group 1 bit 5
        clear_all();
        pulse(1, 32'h0000_0020);
        idle(1);
        rd(4, d);  chk("R1 group1 status", d, 32'h0000_0020);
        rd(0, d);  chk("R1 group0 untouched", d, 32'h0);
        rd(8, d);  chk("R1 group2 untouched", d, 32'h0);

        // R2: partial 1-to-clear
        clear_all();
        pulse(0, 32'h0000_F00F);
        wr(0, 32'h0000_0003);
        rd(0, d);  chk("R2 partial clear", d, 32'h0000_F00C);
        wr(0, 32'h0);
        rd(0, d);  chk("R2 zero write no effect", d, 32'h0000_F00C);

        // R4 R10: mask set/clear ports
        wr(1, 32'h0000_00F0);
        wr(1, 32'h0000_0300);
        rd(1, d);  chk("R4 set accumulates", d, 32'h0000_03F0);
        wr(2, 32'h0000_0110);
        rd(1, d);  chk("R4 clear removes written bits", d, 32'h0000_02E0);
        rd(2, d);  chk("R10 clear port reads mask", d, 32'h0000_02E0);
        wr(2, 32'h0);
        rd(2, d);  chk("R4 zero clear no effect", d, 32'h0000_02E0);

        // R5: write to result address ignored
        wr(3, 32'hFFFF_FFFF);
        rd(0, d);  chk("R5 result write ignored status", d, 32'h0000_F00C);
        rd(1, d);  chk("R5 result write ignored mask", d, 32'h0000_02E0);

        // R8: all ones clears the group
        wr(0, 32'hFFFF_FFFF);
        rd(0, d);  chk("R8 all ones clears", d, 32'h0);

        // R9: event and clear on the same bit in the same cycle
        pulse(0, 32'h0000_0018);
        @(negedge clk);
        evt_i[3] = 1'b1;
        bus_wr = 1'b1; bus_addr = AW'(0); bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        evt_i = '0; bus_wr = 1'b0; bus_wdata = '0;
        rd(0, d);  chk("R9 set wins over clear", d, 32'h0000_0008);

        // R7: line holds while another bit pends
        clear_all();
        wr(9, 32'h0000_0003);
        wr(GATE, 32'h4);
        pulse(2, 32'h0000_0003);
        idle(1);
        chk("R7 line up with two pending", 32'(irq_o[2]), 32'h1);
        wr(8, 32'h0000_0001);
        idle(1);
        chk("R7 line held with one pending", 32'(irq_o[2]), 32'h1);
        rd(11, d); chk("R7 remaining result", d, 32'h0000_0002);
        wr(8, 32'h0000_0002);
        idle(1);
        chk("R7 line drops when none pending", 32'(irq_o[2]), 32'h0);

        // R6: one-cycle latency on gate changes
        clear_all();
        wr(1, 32'h0000_0001);
        wr(GATE, 32'h1);
        pulse(0, 32'h0000_0001);
        idle(1);
        chk("R6 line up", 32'(irq_o), 32'h1);
        wr(GATE, 32'h0);
        chk("R6 line still up one cycle", 32'(irq_o), 32'h1);
        idle(1);
        chk("R6 line gated off", 32'(irq_o), 32'h0);
        rd(0, d);  chk("R6 status kept while gated", d, 32'h0000_0001);
        wr(GATE, 32'h1);
        chk("R6 line still low one cycle", 32'(irq_o), 32'h0);
        idle(1);
        chk("R6 line reopened", 32'(irq_o), 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule